// File: doc/BRIEF.md
# Successive-Approximation A/D Conversion Sequencer

This block is the digital control half of a 12-bit successive-approximation A/D converter inside a microcontroller. Software drives a start bit, a power-off bit, a reference-select bit, a 3-bit clock-divide code, an interrupt enable and an interrupt clear. The block reports a busy flag, a sticky completion flag, an interrupt output and the 12-bit result. The analog half is outside the block. It receives a 12-bit trial code for its DAC and returns one comparator bit, which is 1 when the sampled input is greater than or equal to the trial code.

The system clock is not divided into a new clock. A conversion-clock enable pulse is derived from it, and every sequencing step advances only on that pulse. A conversion starts when the start bit goes high for at least one cycle and then falls. If software keeps the start bit high, the sequencer stays in reset and the busy flag stays high. After the converter is powered up, a settling interval must pass before any start is accepted.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A conversion is accepted on the first clock edge that sees `start_bit` low after a cycle in which it was high. `busy` is 1 in the cycle that follows that edge.
- R2: `busy` equals the value `start_bit` had at the previous clock edge, ORed with "conversion in progress". While `start_bit` is high, any conversion in progress is abandoned and no new one runs.
- R3: At the edge that completes a conversion, `busy` drops to 0 and `result` takes its new value in the same cycle.
- R4: `irq_flag` is set at every completion and stays set until the cycle after `irq_clr` is 1. Setting has priority over clearing. `irq` = `irq_flag` AND `irq_en`.
- R5: `conv_ce` pulses for one system clock in every 2^code clocks for `clk_div` codes 0 to 6. The pulse comes when the low `code` bits of a 6-bit counter are all ones. That counter is held at 0 while powered off and otherwise increments on every clock.
- R6: When `clk_div` = 7 or `pwr_off` = 1, `conv_ce` is 0 and no start is accepted. Raising `pwr_off` abandons a conversion in progress, so `busy` is 0 on the next cycle while `start_bit` is low.
- R7: After `pwr_off` falls, a start is accepted only once 64 `conv_ce` pulses have occurred. A start pulse before that is ignored, and `busy` returns to 0.
- R8: `vref_ext` follows `ref_sel`. A value of 1 claims the shared pin for the external reference, and 0 selects the supply rail.
- R9: A conversion uses 16 `conv_ce` pulses: one sample, two idle, twelve decisions and one latch. Decisions go from bit 11 down to bit 0. During the decision on bit k, `dac_code` is the bits already kept with bit k set, and the bit is kept when `cmp_in` is 1. Outside decisions, `dac_code` shows the kept bits. With `clk_div` = 0, `busy` is high for 16 cycles after the accept edge.
- R10: `result` resets to 0 and changes only at completion. An abandoned conversion leaves it unchanged.
- R11: A start pulse during a conversion restarts the sequence from the sample step. The earlier conversion produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_bit | input | 1 | Software start/reset control bit |
| pwr_off | input | 1 | 1 powers the converter down |
| ref_sel | input | 1 | Reference choice: 0 supply, 1 external pin |
| clk_div | input | 3 | Conversion clock divide code (2^code, 7 = none) |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Software clear of the completion flag |
| cmp_in | input | 1 | Comparator: 1 when input >= dac_code |
| busy | output | 1 | Active-high busy/end-of-conversion flag |
| irq_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| conv_ce | output | 1 | Conversion clock enable pulse |
| vref_ext | output | 1 | External reference / pin claim |
| dac_code | output | 12 | Trial code to the DAC |
| result | output | 12 | Last completed conversion result |

## Verification
Several properties are checked on every cycle by the assertions. A held start bit forces busy on the next cycle. Completion clears busy. A rejected or power-aborted start leaves busy low. The completion flag stays set until it is cleared. The phase advances by one on each enabled step. An abort never disturbs the result. The divider's rate at code 1 and the settle counter's dependence on conversion-clock pulses are also asserted. Other behaviour can only be shown by the bench's scenarios, run against a behavioural model on every clock. These cover the actual bit values the search produces (full scale, zero and mid-codes), the exact length of a conversion at each divide code, restart by a second pulse, rejection before settling, and the interplay of the interrupt enable and clear.

// File: rtl/adc_seq_pkg.sv
// Shared defaults and step classification for the A/D conversion sequencer.
// Assumes phase numbering: 0 sample, then idle steps, then one step per
// result bit (MSB first), then one latch step.
package adc_seq_pkg;
    localparam int ADC_RES_W       = 12;
    localparam int ADC_SEL_W       = 3;
    localparam int ADC_SETTLE_CLKS = 64;
    localparam int ADC_IDLE_CLKS   = 2;

    typedef enum logic [1:0] {
        STEP_SAMPLE,
        STEP_IDLE,
        STEP_DECIDE,
        STEP_LATCH
    } step_e;

    // Map a phase number to the kind of work done in it.
    function automatic step_e step_of(int phase, int first_bit, int latch);
        if (phase == 0)         return STEP_SAMPLE;
        if (phase < first_bit)  return STEP_IDLE;
        if (phase < latch)      return STEP_DECIDE;
        return STEP_LATCH;
    endfunction
endpackage

// File: rtl/adc_clk_gen.sv
// Conversion clock enable generator.
// Produces a one-cycle pulse every 2^div_sel system clocks from a free-running
// counter; the all-ones code and power-off give no pulse at all.
// Assumes the counter is wide enough for the largest ratio (2^(2^SEL_W-2)).
module adc_clk_gen #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_off,
    input  logic [SEL_W-1:0] div_sel,
    output logic             conv_tick
);
    localparam int CNT_W = (1 << SEL_W) - 2;
    localparam logic [SEL_W-1:0] SEL_NONE = '1;

    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] div_mask;

    // Free-running prescale counter, parked at zero while powered down.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_off) div_cnt <= '0;
        else                   div_cnt <= div_cnt + 1'b1;
    end

    // Low-bit mask for the selected ratio and the resulting enable pulse.
    always_comb begin
        span      = (CNT_W + 1)'(1) << div_sel;
        div_mask  = CNT_W'(span - 1'b1);
        conv_tick = !pwr_off && (div_sel != SEL_NONE) &&
                    ((div_cnt & div_mask) == div_mask);
    end

    // At divide-by-2 with a steady code, pulses never come back to back.
    p_half_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_tick && div_sel == SEL_W'(1) && $stable(div_sel) && !$past(pwr_off))
        |-> !$past(conv_tick));
endmodule

// File: rtl/adc_settle.sv
// Power-up settling timer.
// Counts conversion clock pulses after power-on and reports ready once the
// required count is reached; power-off restarts it.
module adc_settle #(
    parameter int SETTLE_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_off,
    input  logic conv_tick,
    output logic ready
);
    localparam int CW = $clog2(SETTLE_CLKS + 1);
    localparam logic [CW-1:0] FULL = CW'(SETTLE_CLKS);

    logic [CW-1:0] settle_cnt;

    // Saturating count of conversion clocks since the last power-on.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_off)                   settle_cnt <= '0;
        else if (conv_tick && settle_cnt != FULL) settle_cnt <= settle_cnt + 1'b1;
    end

    assign ready = (settle_cnt == FULL);

    // Ready can only appear right after a conversion clock pulse.
    p_ready_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(conv_tick));
endmodule

// File: rtl/adc_sar_core.sv
// Successive-approximation step sequencer.
// Walks sample, idle, RES_W decision and latch steps, one per conversion clock
// pulse; abort wins over go, go restarts from the sample step.
// Assumes cmp_in is valid for the trial_code presented in the same cycle.
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 12,
    parameter int IDLE_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_tick,
    input  logic             go,
    input  logic             abort,
    input  logic             cmp_in,
    output logic             active,
    output logic             done,
    output logic [RES_W-1:0] trial_code,
    output logic [RES_W-1:0] result
);
    localparam int FIRST_BIT = 1 + IDLE_CLKS;
    localparam int LATCH     = FIRST_BIT + RES_W;
    localparam int PH_W      = $clog2(LATCH + 1);

    logic [PH_W-1:0]  phase_q;
    logic             active_q;
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] result_q;
    logic [PH_W-1:0]  bit_pos;
    logic [RES_W-1:0] trial_mask;
    step_e            step;

    // Decode the current step and the bit under trial.
    always_comb begin
        step       = step_of(int'(phase_q), FIRST_BIT, LATCH);
        bit_pos    = PH_W'(LATCH - 1) - phase_q;
        trial_mask = (active_q && step == STEP_DECIDE) ? (RES_W'(1) << bit_pos) : '0;
        trial_code = sar_q | trial_mask;
        done       = active_q && conv_tick && step == STEP_LATCH && !abort && !go;
    end

    // Step sequencing, bit decisions and atomic result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            active_q <= 1'b0;
            sar_q    <= '0;
            result_q <= '0;
        end else if (abort) begin
            phase_q  <= '0;
            active_q <= 1'b0;
        end else if (go) begin
            phase_q  <= '0;
            active_q <= 1'b1;
            sar_q    <= '0;
        end else if (active_q && conv_tick) begin
            if (step == STEP_DECIDE && cmp_in) sar_q <= sar_q | trial_mask;
            if (step == STEP_LATCH) begin
                result_q <= sar_q;
                active_q <= 1'b0;
                phase_q  <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign active = active_q;
    assign result = result_q;

    // Each enabled step moves the phase forward by exactly one.
    p_phase_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && conv_tick && !abort && !go && step != STEP_LATCH)
        |=> (phase_q == $past(phase_q) + 1'b1));

    // An aborted sequence never disturbs the stored result.
    p_abort_keeps_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> $stable(result_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
// A/D conversion sequencing controller (top).
// Detects the start pulse, gates acceptance on power, settling and a valid
// divide code, drives the busy and completion flags, and wires the prescaler,
// settling timer and SAR sequencer together.
// Assumes all control inputs are synchronous to clk.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = ADC_RES_W,
    parameter int SEL_W       = ADC_SEL_W,
    parameter int SETTLE_CLKS = ADC_SETTLE_CLKS,
    parameter int IDLE_CLKS   = ADC_IDLE_CLKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_bit,
    input  logic             pwr_off,
    input  logic             ref_sel,
    input  logic [SEL_W-1:0] clk_div,
    input  logic             irq_en,
    input  logic             irq_clr,
    input  logic             cmp_in,
    output logic             busy,
    output logic             irq_flag,
    output logic             irq,
    output logic             conv_ce,
    output logic             vref_ext,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);
    logic start_q, irq_q;
    logic tick, ready, active, done;
    logic fall, accept, abort;

    adc_clk_gen #(.SEL_W(SEL_W)) u_clk_gen (
        .clk(clk), .rst_n(rst_n), .pwr_off(pwr_off),
        .div_sel(clk_div), .conv_tick(tick)
    );

    adc_settle #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
        .clk(clk), .rst_n(rst_n), .pwr_off(pwr_off),
        .conv_tick(tick), .ready(ready)
    );

    adc_sar_core #(.RES_W(RES_W), .IDLE_CLKS(IDLE_CLKS)) u_core (
        .clk(clk), .rst_n(rst_n), .conv_tick(tick), .go(accept),
        .abort(abort), .cmp_in(cmp_in), .active(active), .done(done),
        .trial_code(dac_code), .result(result)
    );

    // Start pulse decode and acceptance gating.
    always_comb begin
        fall   = start_q && !start_bit;
        abort  = start_bit || pwr_off;
        accept = fall && ready && !pwr_off && (clk_div != '1);
    end

    // Previous start bit, for falling-edge detection and the held-reset flag.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start_bit;
    end

    // Sticky completion flag; a completion beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (done)    irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    assign busy     = start_q || active;
    assign irq_flag = irq_q;
    assign irq      = irq_q && irq_en;
    assign conv_ce  = tick;
    assign vref_ext = ref_sel;

    p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_bit |=> busy);

    p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && irq_flag));

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    p_power_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_off && !start_bit) |=> !busy);

    p_reject_unsettled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !ready) |=> !busy);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n, start_bit, pwr_off, ref_sel, irq_en, irq_clr, cmp_in;
    logic [2:0] clk_div;
    logic busy, irq_flag, irq, conv_ce, vref_ext;
    logic [11:0] dac_code, result;
    int vin;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_bit(start_bit), .pwr_off(pwr_off),
        .ref_sel(ref_sel), .clk_div(clk_div), .irq_en(irq_en), .irq_clr(irq_clr),
        .cmp_in(cmp_in), .busy(busy), .irq_flag(irq_flag), .irq(irq),
        .conv_ce(conv_ce), .vref_ext(vref_ext), .dac_code(dac_code), .result(result)
    );

    // Analog side: comparator against the DAC trial code.
    assign cmp_in = (vin >= int'(dac_code));

    // Behavioural reference state.
    int m_cnt, m_settle, m_sq, m_act, m_ph, m_sar, m_res, m_flag;

    function automatic int m_tick();
        int mask;
        if (pwr_off || clk_div == 3'd7) return 0;
        mask = (1 << clk_div) - 1;
        return ((m_cnt & mask) == mask) ? 1 : 0;
    endfunction

    function automatic int m_dac();
        if (m_act != 0 && m_ph >= 3 && m_ph <= 14) return m_sar | (1 << (14 - m_ph));
        return m_sar;
    endfunction

    always @(posedge clk) begin
        int tk, cmpv, acc, abrt, dn;
        if (!rst_n) begin
            m_cnt = 0; m_settle = 0; m_sq = 0; m_act = 0;
            m_ph = 0; m_sar = 0; m_res = 0; m_flag = 0;
        end else begin
            tk   = m_tick();
            cmpv = (vin >= m_dac()) ? 1 : 0;
            acc  = (m_sq != 0 && !start_bit && m_settle == 64 && !pwr_off && clk_div != 3'd7) ? 1 : 0;
            abrt = (start_bit || pwr_off) ? 1 : 0;
            dn   = 0;
            if (abrt != 0) begin
                m_act = 0; m_ph = 0;
            end else if (acc != 0) begin
                m_act = 1; m_ph = 0; m_sar = 0;
            end else if (m_act != 0 && tk != 0) begin
                if (m_ph >= 3 && m_ph <= 14 && cmpv != 0) m_sar = m_sar | (1 << (14 - m_ph));
                if (m_ph == 15) begin
                    m_res = m_sar; m_act = 0; m_ph = 0; dn = 1;
                end else m_ph = m_ph + 1;
            end
            if (dn != 0)      m_flag = 1;
            else if (irq_clr) m_flag = 0;
            if (pwr_off)                         m_settle = 0;
            else if (tk != 0 && m_settle < 64)   m_settle = m_settle + 1;
            m_cnt = pwr_off ? 0 : (m_cnt + 1) % 64;
            m_sq  = start_bit ? 1 : 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the edges.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(int'(busy) == ((m_sq != 0 || m_act != 0) ? 1 : 0), "R2 busy model", busy, (m_sq != 0 || m_act != 0) ? 1 : 0);
            chk(int'(irq_flag) == m_flag, "R4 irq_flag model", irq_flag, m_flag);
            chk(int'(irq) == ((m_flag != 0 && irq_en) ? 1 : 0), "R4 irq model", irq, (m_flag != 0 && irq_en) ? 1 : 0);
            chk(int'(conv_ce) == m_tick(), "R5 conv_ce model", conv_ce, m_tick());
            chk(vref_ext == ref_sel, "R8 vref_ext model", vref_ext, ref_sel);
            chk(int'(dac_code) == m_dac(), "R9 dac_code model", dac_code, m_dac());
            chk(int'(result) == m_res, "R10 result model", result, m_res);
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_bit = 1'b1;
        @(negedge clk) start_bit = 1'b0;
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #2;
            if (busy) n++;
            else break;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, pulses;
        rst_n = 1'b0; start_bit = 1'b0; pwr_off = 1'b1; ref_sel = 1'b0;
        clk_div = 3'd0; irq_en = 1'b1; irq_clr = 1'b0; vin = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_cycles(1);
        chk(busy == 1'b0, "R2 reset busy", busy, 0);
        chk(irq_flag == 1'b0, "R4 reset flag", irq_flag, 0);
        chk(result == 12'd0, "R10 reset result", result, 0);
        chk(conv_ce == 1'b0, "R6 powered off no clock", conv_ce, 0);

        @(negedge clk) ref_sel = 1'b1;
        #2 chk(vref_ext == 1'b1, "R8 external ref", vref_ext, 1);
        @(negedge clk) ref_sel = 1'b0;
        #2 chk(vref_ext == 1'b0, "R8 supply ref", vref_ext, 0);

        // Start before settling is ignored.
        @(negedge clk) pwr_off = 1'b0;
        wait_cycles(5);
        pulse_start();
        wait_cycles(20);
        chk(busy == 1'b0, "R7 early start ignored busy", busy, 0);
        chk(irq_flag == 1'b0, "R7 early start no flag", irq_flag, 0);

        // Main conversion after settling.
        wait_cycles(80);
        vin = 2652;
        pulse_start();
        measure_busy(n);
        chk(n == 16, "R9 conversion length div0", n, 16);
        chk(n >= 1, "R1 busy after falling start", n, 16);
        chk(result == 12'd2652, "R9 mid-code result", result, 2652);
        chk(irq_flag == 1'b1, "R3 completion sets flag", irq_flag, 1);
        chk(irq == 1'b1, "R4 irq enabled", irq, 1);
        @(negedge clk) irq_en = 1'b0;
        #2 chk(irq == 1'b0 && irq_flag == 1'b1, "R4 irq masked flag kept", irq, 0);
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0; irq_en = 1'b1;
        #2 chk(irq_flag == 1'b0, "R4 flag cleared", irq_flag, 0);

        // Held start keeps busy high and the sequencer in reset.
        vin = 0;
        @(negedge clk) start_bit = 1'b1;
        wait_cycles(10);
        chk(busy == 1'b1, "R2 held start busy", busy, 1);
        chk(irq_flag == 1'b0, "R2 held start no completion", irq_flag, 0);
        @(negedge clk) start_bit = 1'b0;
        measure_busy(n);
        chk(n == 16, "R1 release starts conversion", n, 16);
        chk(result == 12'd0, "R9 zero-scale result", result, 0);

        // Abort by held start keeps the old result, then full scale.
        vin = 4095;
        pulse_start();
        wait_cycles(6);
        @(negedge clk) start_bit = 1'b1;
        wait_cycles(3);
        chk(busy == 1'b1, "R2 abort busy high", busy, 1);
        chk(result == 12'd0, "R10 abort keeps result", result, 0);
        @(negedge clk) start_bit = 1'b0;
        measure_busy(n);
        chk(result == 12'd4095, "R9 full-scale result", result, 4095);

        // Restart by a second pulse during a conversion.
        vin = 1234;
        pulse_start();
        wait_cycles(8);
        vin = 77;
        pulse_start();
        measure_busy(n);
        chk(n == 16, "R11 restart full length", n, 16);
        chk(result == 12'd77, "R11 restart result", result, 77);

        // Divide by 4.
        @(negedge clk) clk_div = 3'd2;
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #2;
            if (conv_ce) pulses++;
        end
        chk(pulses == 10, "R5 div4 pulse count", pulses, 10);
        vin = 3000;
        pulse_start();
        measure_busy(n);
        chk(n >= 61 && n <= 64, "R5 div4 conversion length", n, 64);
        chk(result == 12'd3000, "R9 div4 result", result, 3000);

        // Code 7: no clock, no conversion.
        @(negedge clk) clk_div = 3'd7;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #2;
            if (conv_ce) pulses++;
        end
        chk(pulses == 0, "R6 code7 no clock", pulses, 0);
        pulse_start();
        wait_cycles(3);
        chk(busy == 1'b0, "R6 code7 start ignored", busy, 0);

        // Power-off mid conversion.
        @(negedge clk) clk_div = 3'd0;
        vin = 500;
        pulse_start();
        wait_cycles(5);
        @(negedge clk) pwr_off = 1'b1;
        #2 chk(conv_ce == 1'b0, "R6 power off no clock", conv_ce, 0);
        wait_cycles(1);
        chk(busy == 1'b0, "R6 power off abort", busy, 0);
        chk(result == 12'd3000, "R10 power abort keeps result", result, 3000);
        @(negedge clk) pwr_off = 1'b0;
        pulse_start();
        wait_cycles(5);
        chk(busy == 1'b0, "R7 restart after power-on ignored", busy, 0);
        wait_cycles(80);
        pulse_start();
        measure_busy(n);
        chk(n == 16, "R7 accepted after settle", n, 16);
        chk(result == 12'd500, "R9 result after settle", result, 500);

        wait_cycles(4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule